// File: doc/BRIEF.md
# Pipeline breakpoint debug-entry controller

This block follows instruction breakpoints through a three-stage fetch, decode and execute pipeline and decides when the core halts in debug state. A breakpoint request is sampled together with each fetched instruction, and the resulting mark travels with that instruction. The halt happens only when the marked instruction reaches execute. The marked instruction is never executed, so the state visible in debug is the state just before it. The mark takes effect whether the instruction's condition passes or fails.

A taken branch or PC write in execute flushes the younger instructions and redirects fetch, which discards any marks they carry. While halted, fetch and pipeline advance are frozen. A one-cycle restart pulse leaves debug state and reloads fetch from the address of the instruction that caused the halt, with an empty pipeline. The fetch address is produced inside the block and is offered on a port. Instruction decoding and register state are modelled by the condition, branch and target inputs.

Top module: `bkpt_debug_ctrl`

## Requirements
- R1: After reset, dbg_ack_o, ex_valid_o, ex_enable_o and flush_o are 0 and fetch_addr_o equals RESET_ADDR (default 0).
- R2: Each accepted fetch (fetch_valid_i high while not halted) advances fetch_addr_o by 4. The instruction then appears in execute (ex_valid_o high, ex_addr_o equal to its fetch address) two clock edges after the edge that fetched it. While a marked instruction sits in fetch or decode, dbg_ack_o stays 0 and the older unmarked instructions execute with ex_enable_o high.
- R3: While a marked instruction is in execute, ex_enable_o is 0. dbg_ack_o rises on the next edge.
- R4: A marked instruction whose condition fails (ex_cond_pass_i low) still holds ex_enable_o at 0 and still causes debug entry.
- R5: An unmarked instruction in execute with ex_branch_i and ex_cond_pass_i high drives flush_o high in that cycle. After the next edge, fetch_addr_o equals ex_target_i and the pipeline is empty. The marks of the discarded instructions never cause debug entry.
- R6: A branch in execute whose condition fails leaves flush_o at 0 and removes no instruction, so a marked instruction behind it still causes debug entry.
- R7: While dbg_ack_o is high, fetch_addr_o is stable and ex_valid_o and ex_enable_o are 0, whatever fetch_valid_i does.
- R8: In debug state, restart_addr_o holds the address of the marked instruction. A restart_i pulse clears dbg_ack_o on the next edge, sets fetch_addr_o to that address and leaves the pipeline empty, so the refetched instruction reaches execute three edges later.
- R9: A bkpt_req_i that is high while fetch_valid_i is low marks no instruction.
- R10: A restart_i pulse while dbg_ack_o is low has no effect on fetch_addr_o or dbg_ack_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid_i | input | 1 | An instruction is fetched from fetch_addr_o this cycle |
| bkpt_req_i | input | 1 | Breakpoint request for the instruction fetched this cycle |
| ex_cond_pass_i | input | 1 | Condition of the instruction in execute passes |
| ex_branch_i | input | 1 | Instruction in execute is a branch or writes the PC |
| ex_target_i | input | AW | Branch or PC-write target address |
| restart_i | input | 1 | One-cycle request to leave debug state |
| fetch_addr_o | output | AW | Address of the next fetch |
| ex_valid_o | output | 1 | Execute stage holds an instruction |
| ex_addr_o | output | AW | Address of the instruction in execute |
| ex_enable_o | output | 1 | Instruction in execute may execute |
| flush_o | output | 1 | Taken branch or PC write discards the younger instructions |
| dbg_ack_o | output | 1 | Core is in debug state |
| restart_addr_o | output | AW | Address at which execution resumes after debug |

## Verification
The bench places a marked instruction behind two ordinary ones. It checks that the halt waits for execute: a design that acted at fetch or decode would raise dbg_ack_o while older instructions still needed to execute. It repeats this with the condition failing, which catches a design that lets the condition gate the halt, and it checks the restart address and the refetch timing, which catch a design that resumes at the following instruction. A taken branch ahead of a marked instruction must cancel the halt, while a not-taken branch must not; a flush that missed the marks, or flushed regardless of the condition, shows up here. Requests without a fetch and restarts outside debug are also sent, and either one would otherwise create a phantom halt or a stray redirect.

// File: rtl/bkpt_dbg_pkg.sv
package bkpt_dbg_pkg;

  typedef enum logic {
    DBG_RUN  = 1'b0,
    DBG_HALT = 1'b1
  } dbg_state_t;

endpackage

// File: rtl/bkpt_rst_sync.sv
module bkpt_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[DEPTH-1];

endmodule

// File: rtl/bkpt_fetch_pc.sv
module bkpt_fetch_pc #(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   STEP       = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid_i,
  input  logic          hold_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] target_i,
  input  logic          restart_i,
  input  logic [AW-1:0] restart_addr_i,
  output logic [AW-1:0] pc_o
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  logic          pc_en;

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    if (restart_i) begin
      pc_en = 1'b1;
      pc_d  = restart_addr_i;
    end else if (redirect_i) begin
      pc_en = 1'b1;
      pc_d  = target_i;
    end else if (!hold_i && fetch_valid_i) begin
      pc_en = 1'b1;
      pc_d  = pc_q + STEP_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_ADDR;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

  AST_RESTART_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (pc_q == $past(restart_addr_i))) else $error("restart load"); // R8
  AST_REDIRECT_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_i && !restart_i) |=> (pc_q == $past(target_i))) else $error("redirect load"); // R5
  AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !restart_i && !redirect_i) |=> $stable(pc_q)) else $error("pc moved in hold"); // R7

endmodule

// File: rtl/bkpt_pipe.sv
module bkpt_pipe #(
  parameter int unsigned AW     = 32,
  parameter int unsigned STAGES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          kill_i,
  input  logic          fetch_valid_i,
  input  logic          bkpt_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  output logic          ex_valid_o,
  output logic          ex_tag_o,
  output logic [AW-1:0] ex_addr_o
);

  localparam int unsigned EX = STAGES - 1;

  logic [STAGES-1:0] valid_q;
  logic [STAGES-1:0] tag_q;
  logic [AW-1:0]     addr_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic          in_v;
    logic          in_t;
    logic [AW-1:0] in_a;
    logic          v_q, v_d, t_q, t_d;
    logic [AW-1:0] a_q, a_d;
    logic          st_en;

    if (i == 0) begin : g_head
      assign in_v = fetch_valid_i;
      assign in_t = fetch_valid_i & bkpt_req_i;
      assign in_a = fetch_addr_i;
    end else begin : g_body
      assign in_v = valid_q[i-1];
      assign in_t = tag_q[i-1];
      assign in_a = addr_q[i-1];
    end

    always_comb begin
      st_en = 1'b0;
      v_d   = v_q;
      t_d   = t_q;
      a_d   = a_q;
      if (kill_i) begin
        st_en = 1'b1;
        v_d   = 1'b0;
        t_d   = 1'b0;
      end else if (adv_i) begin
        st_en = 1'b1;
        v_d   = in_v;
        t_d   = in_t;
        a_d   = in_a;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= 1'b0;
        a_q <= '0;
      end else if (st_en) begin
        v_q <= v_d;
        t_q <= t_d;
        a_q <= a_d;
      end
    end

    assign valid_q[i] = v_q;
    assign tag_q[i]   = t_q;
    assign addr_q[i]  = a_q;
  end

  assign ex_valid_o = valid_q[EX];
  assign ex_tag_o   = tag_q[EX];
  assign ex_addr_o  = addr_q[EX];

  AST_KILL_EMPTIES_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (valid_q == '0 && tag_q == '0)) else $error("kill left entries"); // R5
  AST_NO_FETCH_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !kill_i && !fetch_valid_i) |=> !tag_q[0]) else $error("tag without fetch"); // R9
  AST_STALL_FREEZES_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !kill_i) |=> ($stable(valid_q) && $stable(tag_q))) else $error("pipe moved in stall"); // R7

endmodule

// File: rtl/bkpt_dbg_fsm.sv
module bkpt_dbg_fsm
  import bkpt_dbg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [AW-1:0] hit_addr_i,
  input  logic          restart_i,
  output logic          halted_o,
  output logic          restart_take_o,
  output logic [AW-1:0] saved_addr_o
);

  dbg_state_t    state_q, state_d;
  logic [AW-1:0] saved_q, saved_d;
  logic          saved_en;

  always_comb begin
    state_d        = state_q;
    saved_d        = saved_q;
    saved_en       = 1'b0;
    restart_take_o = 1'b0;
    case (state_q)
      DBG_RUN: begin
        if (hit_i) begin
          state_d  = DBG_HALT;
          saved_d  = hit_addr_i;
          saved_en = 1'b1;
        end
      end
      DBG_HALT: begin
        if (restart_i) begin
          state_d        = DBG_RUN;
          restart_take_o = 1'b1;
        end
      end
      default: state_d = DBG_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DBG_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_q <= '0;
    end else if (saved_en) begin
      saved_q <= saved_d;
    end
  end

  assign halted_o     = (state_q == DBG_HALT);
  assign saved_addr_o = saved_q;

  AST_HIT_ENTERS_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> (halted_o && saved_addr_o == $past(hit_addr_i))) else $error("no debug entry"); // R3
  AST_HALT_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !restart_i) |=> halted_o) else $error("left debug unasked"); // R8
  AST_RESTART_IN_RUN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_o && !hit_i) |=> !halted_o) else $error("spurious halt"); // R10

endmodule

// File: rtl/bkpt_debug_ctrl.sv
module bkpt_debug_ctrl #(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   STAGES     = 3,
  parameter int unsigned   STEP       = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid_i,
  input  logic          bkpt_req_i,
  input  logic          ex_cond_pass_i,
  input  logic          ex_branch_i,
  input  logic [AW-1:0] ex_target_i,
  input  logic          restart_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          ex_valid_o,
  output logic [AW-1:0] ex_addr_o,
  output logic          ex_enable_o,
  output logic          flush_o,
  output logic          dbg_ack_o,
  output logic [AW-1:0] restart_addr_o
);

  logic          rst_n_s;
  logic          ex_valid, ex_tag;
  logic [AW-1:0] ex_addr;
  logic          halted, restart_take;
  logic [AW-1:0] saved_addr;
  logic [AW-1:0] pc;
  logic          hit, redirect, kill, adv, pc_hold;

  bkpt_rst_sync #(.DEPTH(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  always_comb begin
    hit      = ex_valid & ex_tag & ~halted;
    redirect = ex_valid & ~ex_tag & ex_branch_i & ex_cond_pass_i & ~halted;
    kill     = hit | redirect;
    adv      = ~halted;
    pc_hold  = halted | hit;
  end

  bkpt_fetch_pc #(.AW(AW), .STEP(STEP), .RESET_ADDR(RESET_ADDR)) u_pc (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .fetch_valid_i  (fetch_valid_i),
    .hold_i         (pc_hold),
    .redirect_i     (redirect),
    .target_i       (ex_target_i),
    .restart_i      (restart_take),
    .restart_addr_i (saved_addr),
    .pc_o           (pc)
  );

  bkpt_pipe #(.AW(AW), .STAGES(STAGES)) u_pipe (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .adv_i         (adv),
    .kill_i        (kill),
    .fetch_valid_i (fetch_valid_i),
    .bkpt_req_i    (bkpt_req_i),
    .fetch_addr_i  (pc),
    .ex_valid_o    (ex_valid),
    .ex_tag_o      (ex_tag),
    .ex_addr_o     (ex_addr)
  );

  bkpt_dbg_fsm #(.AW(AW)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .hit_i          (hit),
    .hit_addr_i     (ex_addr),
    .restart_i      (restart_i),
    .halted_o       (halted),
    .restart_take_o (restart_take),
    .saved_addr_o   (saved_addr)
  );

  assign fetch_addr_o   = pc;
  assign ex_valid_o     = ex_valid;
  assign ex_addr_o      = ex_addr;
  assign ex_enable_o    = ex_valid & ~ex_tag & ~halted;
  assign flush_o        = redirect;
  assign dbg_ack_o      = halted;
  assign restart_addr_o = saved_addr;

  AST_HALT_BLOCKS_EXEC: assert property (@(posedge clk) disable iff (!rst_n_s)
    dbg_ack_o |-> (!ex_enable_o && !ex_valid_o)) else $error("exec in debug"); // R7
  AST_ENTRY_NOT_EXECUTED: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(dbg_ack_o)) |-> !$past(ex_enable_o)) else $error("marked insn executed"); // R3
  AST_FLUSH_OUTSIDE_DEBUG: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush_o |=> !dbg_ack_o) else $error("flush led to debug"); // R5

endmodule

// File: tb/bkpt_debug_ctrl_test.sv
`timescale 1ns/100ps
module bkpt_debug_ctrl_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid_i, bkpt_req_i, ex_cond_pass_i, ex_branch_i, restart_i;
  logic [AW-1:0] ex_target_i;
  logic [AW-1:0] fetch_addr_o, ex_addr_o, restart_addr_o;
  logic          ex_valid_o, ex_enable_o, flush_o, dbg_ack_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bkpt_debug_ctrl uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid_i  (fetch_valid_i),
    .bkpt_req_i     (bkpt_req_i),
    .ex_cond_pass_i (ex_cond_pass_i),
    .ex_branch_i    (ex_branch_i),
    .ex_target_i    (ex_target_i),
    .restart_i      (restart_i),
    .fetch_addr_o   (fetch_addr_o),
    .ex_valid_o     (ex_valid_o),
    .ex_addr_o      (ex_addr_o),
    .ex_enable_o    (ex_enable_o),
    .flush_o        (flush_o),
    .dbg_ack_o      (dbg_ack_o),
    .restart_addr_o (restart_addr_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic fv, input logic bp, input logic br, input logic cp,
                     input logic [AW-1:0] tgt, input logic rs);
    fetch_valid_i  = fv;
    bkpt_req_i     = bp;
    ex_branch_i    = br;
    ex_cond_pass_i = cp;
    ex_target_i    = tgt;
    restart_i      = rs;
    #1;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic do_reset();
    cyc(0, 0, 0, 1, 0, 0);
    rst_n = 1'b0;
    repeat (3) nxt();
    rst_n = 1'b1;
    repeat (3) nxt();
  endtask

  task automatic t_reset();
    do_reset();
    cyc(0, 0, 0, 1, 0, 0);
    chk("R1", "dbg_ack", dbg_ack_o, 0);
    chk("R1", "ex_valid", ex_valid_o, 0);
    chk("R1", "ex_enable", ex_enable_o, 0);
    chk("R1", "flush", flush_o, 0);
    chk("R1", "fetch_addr", fetch_addr_o, 0);
    nxt();
  endtask

  task automatic t_break(input logic cond);
    string rq;
    rq = cond ? "R3" : "R4";
    do_reset();
    cyc(1, 0, 0, cond, 0, 0); chk("R2", "fetch_addr c0", fetch_addr_o, 0); nxt();
    cyc(1, 0, 0, cond, 0, 0); chk("R2", "fetch_addr c1", fetch_addr_o, 4); nxt();
    cyc(1, 1, 0, cond, 0, 0); chk("R2", "fetch_addr c2", fetch_addr_o, 8); nxt();
    cyc(1, 0, 0, cond, 0, 0);
    chk("R2", "ex_addr first", ex_addr_o, 0);
    chk("R2", "ex_enable first", ex_enable_o, 1);
    nxt();
    cyc(1, 0, 0, cond, 0, 0);
    chk("R2", "ex_addr second", ex_addr_o, 4);
    chk("R2", "ex_enable second", ex_enable_o, 1);
    chk("R2", "dbg_ack while mark in decode", dbg_ack_o, 0);
    nxt();
    cyc(1, 0, 0, cond, 0, 0);
    chk(rq, "ex_valid marked", ex_valid_o, 1);
    chk(rq, "ex_addr marked", ex_addr_o, 8);
    chk(rq, "ex_enable marked", ex_enable_o, 0);
    chk(rq, "dbg_ack before entry", dbg_ack_o, 0);
    nxt();
    cyc(1, 0, 0, cond, 0, 0);
    chk(rq, "dbg_ack after entry", dbg_ack_o, 1);
    chk("R8", "restart_addr", restart_addr_o, 8);
    chk("R7", "ex_valid halted", ex_valid_o, 0);
    chk("R7", "fetch_addr halted", fetch_addr_o, 20);
    nxt();
    for (int k = 0; k < 2; k++) begin
      cyc(1, 0, 0, cond, 0, 0);
      chk("R7", "dbg_ack held", dbg_ack_o, 1);
      chk("R7", "fetch_addr frozen", fetch_addr_o, 20);
      chk("R7", "ex_enable halted", ex_enable_o, 0);
      nxt();
    end
    cyc(1, 0, 0, 1, 0, 1); nxt();
    cyc(1, 0, 0, 1, 0, 0);
    chk("R8", "dbg_ack after restart", dbg_ack_o, 0);
    chk("R8", "fetch_addr after restart", fetch_addr_o, 8);
    chk("R8", "ex_valid after restart", ex_valid_o, 0);
    nxt();
    cyc(1, 0, 0, 1, 0, 0); nxt();
    cyc(1, 0, 0, 1, 0, 0); chk("R8", "ex_valid before refetch arrives", ex_valid_o, 0); nxt();
    cyc(1, 0, 0, 1, 0, 0);
    chk("R8", "refetched ex_addr", ex_addr_o, 8);
    chk("R8", "refetched ex_enable", ex_enable_o, 1);
    chk("R8", "no second entry", dbg_ack_o, 0);
    nxt();
  endtask

  task automatic t_branch(input logic cond);
    do_reset();
    cyc(1, 0, 0, 1, 0, 0); nxt();
    cyc(1, 1, 0, 1, 0, 0); nxt();
    cyc(1, 0, 0, 1, 0, 0); nxt();
    cyc(1, 0, 1, cond, 32'h100, 0);
    chk(cond ? "R5" : "R6", "ex_addr branch", ex_addr_o, 0);
    chk(cond ? "R5" : "R6", "flush", flush_o, cond);
    nxt();
    if (cond) begin
      cyc(1, 0, 0, 1, 0, 0);
      chk("R5", "fetch_addr redirected", fetch_addr_o, 32'h100);
      chk("R5", "ex_valid after flush", ex_valid_o, 0);
      chk("R5", "flush dropped", flush_o, 0);
      nxt();
      for (int k = 0; k < 5; k++) begin
        cyc(1, 0, 0, 1, 0, 0);
        chk("R5", "no entry after cancel", dbg_ack_o, 0);
        if (k == 2) chk("R5", "target reaches execute", ex_addr_o, 32'h100);
        nxt();
      end
    end else begin
      cyc(1, 0, 0, 1, 0, 0);
      chk("R6", "marked insn kept", ex_addr_o, 4);
      chk("R6", "marked insn suppressed", ex_enable_o, 0);
      nxt();
      cyc(1, 0, 0, 1, 0, 0);
      chk("R6", "entry behind failed branch", dbg_ack_o, 1);
      chk("R6", "restart_addr", restart_addr_o, 4);
      nxt();
    end
  endtask

  task automatic t_nofetch();
    do_reset();
    cyc(0, 1, 0, 1, 0, 0); nxt();
    cyc(0, 1, 0, 1, 0, 0); nxt();
    cyc(1, 0, 0, 1, 0, 0); chk("R9", "pc held without fetch", fetch_addr_o, 0); nxt();
    cyc(1, 0, 0, 1, 0, 0); nxt();
    cyc(1, 0, 0, 1, 0, 0); nxt();
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 1, 0, 0);
      chk("R9", "no entry", dbg_ack_o, 0);
      if (k < 3) begin
        chk("R9", "ex_addr", ex_addr_o, 32'(4 * k));
        chk("R9", "ex_enable", ex_enable_o, 1);
      end
      nxt();
    end
  endtask

  task automatic t_restart_idle();
    do_reset();
    cyc(1, 0, 0, 1, 0, 0); nxt();
    cyc(1, 0, 0, 1, 0, 1); nxt();
    cyc(0, 0, 0, 1, 0, 0);
    chk("R10", "fetch_addr unaffected", fetch_addr_o, 8);
    chk("R10", "dbg_ack unaffected", dbg_ack_o, 0);
    nxt();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    nxt();
    t_reset();
    t_break(1'b1);
    t_break(1'b0);
    t_branch(1'b1);
    t_branch(1'b0);
    t_nofetch();
    t_restart_idle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule